// File: doc/BRIEF.md
# USB Hub Upstream Port Suspend and Wakeup Control

This block holds the control and status register for the upstream (host-facing) port of a USB hub. Software uses an 8-bit register bus to set two control bits. The first is a wakeup request, which drives the port data lines to the K state so the hub can signal a remote wakeup. The second is a suspend flag. It stops repeater traffic in both directions and asks the transceiver and regulator to enter low power.

The same register also reports the two data line levels. The suspend flag selects how they are reported. While suspended, the readback is transparent and follows the live line levels. While active, the readback shows the levels captured at the most recent end-of-frame sample strobe. This lets software poll the bus during suspend and still see a frame-aligned snapshot during normal traffic.

Software times the length of the wakeup signal. The block holds the K state for as long as the wakeup bit is set.

Top module: `usb_root_port_ctl`

## Requirements
- R1: A synchronous active-low reset clears the wakeup and suspend bits. After reset `line_oe`, `rptr_block` and `lowpwr_req` are 0.
- R2: A write with `bus_sel`=1, `bus_wr`=1 and `bus_addr` equal to `REG_ADDR` stores data bit 4 as the wakeup bit and data bit 3 as the suspend bit. Each is read back at the same bit position from the cycle after the write.
- R3: Register bits 7, 6, 5 and 2 always read 0, whatever value was written to them.
- R4: Bit 1 reads the D+ level and bit 0 reads the D− level. Writes to these two positions have no effect on what they read.
- R5: An access whose address differs from `REG_ADDR` changes no state. During that access `bus_rdata` is 0, and it is also 0 when no read is in progress.
- R6: While the wakeup bit is 1, `line_oe`=1, `dp_out`=0 and `dm_out`=1 (the K state). While it is 0, `line_oe`=0.
- R7: While the suspend bit is 1, read bits 1:0 follow `dp_in`/`dm_in` in the same cycle.
- R8: While the suspend bit is 0, read bits 1:0 show the `dp_in`/`dm_in` values sampled at the last clock edge where `eof2_stb` was 1. They stay unchanged until the next such edge.
- R9: While the suspend bit is 1, `rptr_block` and `lowpwr_req` are both 1. While it is 0, both are 0.
- R10: When a strobe and a change of suspend bit fall on the same edge, the line sample is captured at that edge, and the new mode applies from the next cycle.
- R11: The wakeup K state has no built-in minimum or maximum length. It stays for as long as the bit stays set, and it ends in the cycle after a write clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 unless a matching read |
| dp_in | input | 1 | Sampled D+ line level |
| dm_in | input | 1 | Sampled D− line level |
| eof2_stb | input | 1 | End-of-frame sample strobe |
| dp_out | output | 1 | D+ drive level |
| dm_out | output | 1 | D− drive level |
| line_oe | output | 1 | Line output enable |
| rptr_block | output | 1 | Blocks repeater traffic both ways |
| lowpwr_req | output | 1 | Transceiver/regulator low-power request |

## Verification
A register write takes effect at the clock edge that ends the write cycle. From the following cycle it is visible in the readback, in `line_oe`/`dp_out`/`dm_out`, and in `rptr_block`/`lowpwr_req`. The bench therefore drives each write, lets one edge pass, and then samples a read two nanoseconds after the next falling edge.

In suspend mode the live line readback is combinational, so it is checked in the same cycle as the line change. The frame-latched readback changes only at an edge with the strobe high, so it is checked one cycle after that edge and again after later line changes made with no strobe.

// File: rtl/rp_ctl_pkg.sv
// Package: bit positions and the control-state type shared by the upstream
// port control block. Assumes an 8-bit register image.
package rp_ctl_pkg;
    localparam int BIT_WAKE = 4;
    localparam int BIT_SUSP = 3;
    localparam int BIT_DP   = 1;
    localparam int BIT_DM   = 0;

    typedef struct packed {
        logic wake;
        logic susp;
    } ctl_t;
endpackage

// File: rtl/rp_ctl_reg.sv
// Module: rp_ctl_reg
// Decodes bus accesses to the single register address and holds the wakeup
// and suspend control bits. Assumes one access per cycle, with writes
// landing at the clock edge. Only the two control positions are writable.
module rp_ctl_reg
    import rp_ctl_pkg::*;
#(
    parameter int         AW       = 8,
    parameter int         DW       = 8,
    parameter logic [AW-1:0] REG_ADDR = AW'(8'h5E)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output ctl_t          ctl,
    output logic          rd_hit
);
    logic hit;

    // Address match for any access.
    always_comb begin
        hit    = sel && (addr == REG_ADDR);
        rd_hit = hit && !wr;
    end

    // Control bit storage; only the wakeup and suspend positions are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (hit && wr) begin
            ctl.wake <= wdata[BIT_WAKE];
            ctl.susp <= wdata[BIT_SUSP];
        end
    end
endmodule

// File: rtl/rp_line_view.sv
// Module: rp_line_view
// Produces the D+/D- readback. It is transparent while live_mode is 1,
// and otherwise shows the sample taken at the last edge with the frame
// strobe high. The capture runs on every strobe in either mode. Assumes
// the inputs are already synchronised.
module rp_line_view (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eof2_stb,
    input  logic       dp_in,
    input  logic       dm_in,
    input  logic       live_mode,
    output logic [1:0] view
);
    logic [1:0] snap;

    // Frame-aligned capture of the two line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= 2'b00;
        end else if (eof2_stb) begin
            snap <= {dp_in, dm_in};
        end
    end

    // Mode selection between live and captured levels.
    always_comb begin
        view = live_mode ? {dp_in, dm_in} : snap;
    end
endmodule

// File: rtl/rp_line_drive.sv
// Module: rp_line_drive
// Maps the control bits to the transceiver-side outputs: the K-state drive
// while waking, and the repeater block plus low-power request while
// suspended. Purely combinational; the duration is set by software.
module rp_line_drive
    import rp_ctl_pkg::*;
(
    input  ctl_t ctl,
    output logic line_oe,
    output logic dp_out,
    output logic dm_out,
    output logic rptr_block,
    output logic lowpwr_req
);
    // K state: D+ low, D- high, enabled only while waking.
    always_comb begin
        line_oe    = ctl.wake;
        dp_out     = 1'b0;
        dm_out     = ctl.wake;
        rptr_block = ctl.susp;
        lowpwr_req = ctl.susp;
    end
endmodule

// File: rtl/usb_root_port_ctl.sv
// Module: usb_root_port_ctl
// Top of the upstream port suspend/wakeup control. Joins register decode,
// line readback and drive mapping, and assembles the read image. Assumes
// DW >= 5 so that the control bit positions fit.
module usb_root_port_ctl
    import rp_ctl_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] REG_ADDR = AW'(8'h5E)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dp_in,
    input  logic          dm_in,
    input  logic          eof2_stb,
    output logic          dp_out,
    output logic          dm_out,
    output logic          line_oe,
    output logic          rptr_block,
    output logic          lowpwr_req
);
    ctl_t       ctl;
    logic       rd_hit;
    logic [1:0] view;
    logic [DW-1:0] image;

    rp_ctl_reg #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ctl   (ctl),
        .rd_hit(rd_hit)
    );

    rp_line_view u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .eof2_stb (eof2_stb),
        .dp_in    (dp_in),
        .dm_in    (dm_in),
        .live_mode(ctl.susp),
        .view     (view)
    );

    rp_line_drive u_drive (
        .ctl       (ctl),
        .line_oe   (line_oe),
        .dp_out    (dp_out),
        .dm_out    (dm_out),
        .rptr_block(rptr_block),
        .lowpwr_req(lowpwr_req)
    );

    // Read image: control bits and line view at their positions, rest zero.
    always_comb begin
        image           = '0;
        image[BIT_WAKE] = ctl.wake;
        image[BIT_SUSP] = ctl.susp;
        image[BIT_DP]   = view[1];
        image[BIT_DM]   = view[0];
        bus_rdata       = rd_hit ? image : '0;
    end
endmodule

// File: rtl/rp_ctl_chk.sv
// Module: rp_ctl_chk
// Assertion checker attached to usb_root_port_ctl by bind. It observes
// ports only.
module rp_ctl_chk #(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] REG_ADDR = AW'(8'h5E)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          dp_in,
    input logic          dm_in,
    input logic          eof2_stb,
    input logic          dp_out,
    input logic          dm_out,
    input logic          line_oe,
    input logic          rptr_block,
    input logic          lowpwr_req
);
    logic rd, wr_hit;

    // Bus phase decode seen from the checker side.
    always_comb begin
        rd     = bus_sel && !bus_wr && (bus_addr == REG_ADDR);
        wr_hit = bus_sel && bus_wr && (bus_addr == REG_ADDR);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!line_oe && !rptr_block && !lowpwr_req));

    a_r2_wake_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_wdata[4]) |=> line_oe);

    a_r9_susp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_wdata[3]) |=> (rptr_block && lowpwr_req));

    a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> (bus_rdata[7:5] == 3'b000 && !bus_rdata[2]));

    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (bus_rdata == '0));

    a_r6_k_state: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> (!dp_out && dm_out));

    a_r7_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rptr_block) |-> (bus_rdata[1:0] == {dp_in, dm_in}));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rptr_block && $past(rst_n) && $past(rd && !rptr_block && !eof2_stb))
            |-> $stable(bus_rdata[1:0]));
endmodule

bind usb_root_port_ctl rp_ctl_chk #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dp_in     (dp_in),
    .dm_in     (dm_in),
    .eof2_stb  (eof2_stb),
    .dp_out    (dp_out),
    .dm_out    (dm_out),
    .line_oe   (line_oe),
    .rptr_block(rptr_block),
    .lowpwr_req(lowpwr_req)
);

// File: tb/tb_usb_root_port_ctl.sv
module tb_usb_root_port_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dp_in = 1'b0, dm_in = 1'b0, eof2_stb = 1'b0;
    logic       dp_out, dm_out, line_oe, rptr_block, lowpwr_req;
    int         total = 0, bad = 0;

    always #10 clk = ~clk;

    usb_root_port_ctl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dp_in(dp_in), .dm_in(dm_in), .eof2_stb(eof2_stb),
        .dp_out(dp_out), .dm_out(dm_out), .line_oe(line_oe),
        .rptr_block(rptr_block), .lowpwr_req(lowpwr_req)
    );

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] wdata;
        logic       dp;
        logic       dm;
        logic       stb;
        logic [7:0] exp_rd;
        logic       exp_oe;
        logic       exp_blk;
    } vec_t;

    // Write vector, then a read of REG_ADDR one cycle later.
    localparam vec_t VEC [8] = '{
        '{8'h5E, 8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0}, // R8 capture 10
        '{8'h5E, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0}, // R8 hold
        '{8'h5E, 8'h08, 1'b0, 1'b1, 1'b0, 8'h09, 1'b0, 1'b1}, // R2 R7 R9 live 01
        '{8'h5E, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h1B, 1'b1, 1'b1}, // R3 R4 R6
        '{8'h5F, 8'h00, 1'b0, 1'b0, 1'b1, 8'h18, 1'b1, 1'b1}, // R5 miss
        '{8'h5E, 8'h10, 1'b1, 1'b1, 1'b1, 8'h13, 1'b1, 1'b0}, // R10 capture 11
        '{8'h5E, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0}, // R6 R8
        '{8'h5E, 8'hE7, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0}  // R3 R4
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic start_read(input logic [7:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
    endtask

    initial begin : watchdog
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        @(negedge clk); start_read(8'h5E);
        chk("R1 ctl bits", bus_rdata & 8'hFC, 8'h00);
        chk("R1 oe/blk/lp", {5'b0, line_oe, rptr_block, lowpwr_req}, 8'h00);
        bus_sel = 1'b0;

        // Vector walk
        foreach (VEC[i]) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = VEC[i].addr; bus_wdata = VEC[i].wdata;
            dp_in = VEC[i].dp; dm_in = VEC[i].dm; eof2_stb = VEC[i].stb;
            @(negedge clk);
            eof2_stb = 1'b0;
            start_read(8'h5E);
            chk($sformatf("R2/R3/R4/R7/R8/R10 vec%0d rdata", i), bus_rdata, VEC[i].exp_rd);
            chk($sformatf("R6 vec%0d oe", i), {7'b0, line_oe}, {7'b0, VEC[i].exp_oe});
            if (VEC[i].exp_oe)
                chk($sformatf("R6 vec%0d K", i), {6'b0, dp_out, dm_out}, 8'h01);
            chk($sformatf("R9 vec%0d blk", i), {6'b0, rptr_block, lowpwr_req},
                {6'b0, VEC[i].exp_blk, VEC[i].exp_blk});
        end
        bus_sel = 1'b0;

        // R5: read at another address gives 0; idle gives 0
        @(negedge clk); start_read(8'h5D);
        chk("R5 miss read", bus_rdata, 8'h00);
        bus_sel = 1'b0; #1;
        chk("R5 idle read", bus_rdata, 8'h00);

        // R8: lines change without strobe, readback holds 11 captured earlier
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); dp_in = k[0]; dm_in = k[1];
            start_read(8'h5E);
            chk("R8 hold", bus_rdata, 8'h03);
        end
        bus_sel = 1'b0;

        // R7: live follow in suspend, same cycle
        do_write(8'h5E, 8'h08);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); dp_in = k[1]; dm_in = k[0];
            start_read(8'h5E);
            chk("R7 live", bus_rdata, 8'h08 | 8'(k));
        end
        bus_sel = 1'b0;

        // R11: long wakeup held, then cleared the cycle after the write
        do_write(8'h5E, 8'h10);
        repeat (1000) @(negedge clk);
        #2;
        chk("R11 held oe", {7'b0, line_oe}, 8'h01);
        chk("R11 held K", {6'b0, dp_out, dm_out}, 8'h01);
        do_write(8'h5E, 8'h00);
        #2;
        chk("R11 release", {7'b0, line_oe}, 8'h00);

        // R1: reset mid-run clears set bits
        do_write(8'h5E, 8'h18);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        start_read(8'h5E);
        chk("R1 mid reset ctl", bus_rdata & 8'hFC, 8'h00);
        chk("R1 mid reset out", {5'b0, line_oe, rptr_block, lowpwr_req}, 8'h00);
        bus_sel = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule